// File: doc/BRIEF.md
# Word-Oriented SPI Master with Register Access

This block is a serial peripheral interface master that software drives through five registers spaced eight bytes apart. The control register holds clock phase, clock polarity, chip-select polarity, word length, transfer direction and a chip-select index. It also holds a global enable. While the enable is set, the chosen chip-select line stays active across as many words as software sends. Each write to the transmit register shifts one word of 4 to 32 bits, most significant bit first. The word runs in one of three directions: full-duplex, transmit-only, or receive-only. In receive-only mode the written value is only a trigger.

The serial clock is the system clock divided by 2^N. N is a 4-bit input in the range 1 to 15, so the slowest rate is the system clock over 32768. A status register reports three things: whether a received word is waiting, whether the shifter can take a new word, and whether the shifter is idle. A control field for queued operation and a queue start bit are kept for software and have no effect on shifting.

Top module: `spi_mstr_ctl`

## Requirements
- R1: Register index is byte address bits [AW-1:3]; accesses with nonzero address bits [2:0] are ignored and read as zero. Index 0 is control, 1 status, 2 queue control, 3 transmit data, 4 receive data. Control reads back with mask 0x07FFF1FF. Queue control keeps bit 0 only. Transmit data reads as zero.
- R2: Status bit 0 means a received word is waiting, bit 1 ready for a word, bit 2 idle, bit 4 constant 1, bit 5 constant 0, bit 6 the inverse of bit 0, bit 7 constant 0; after reset it reads 0x56.
- R3: Control bit 26 enables the port and bits 17:14 select a chip-select line. While enabled, only the line whose number equals the index is active, and an index of NCS or more selects none. Control bit 2 gives the active level: 0 drives the active line low, 1 drives it high. Every inactive line sits at the opposite level.
- R4: When idle, the serial clock sits at control bit 1. While shifting, it toggles every 2^(N-1) system cycles, with N = 1 used when div_exp is 0.
- R5: A transmit-data write starts a word only when the port is enabled and the shifter is idle. A write while disabled or while busy is dropped.
- R6: Word length is control bits 8:4 plus one; any length below 4 is treated as 4. Words shift most significant bit first, and each word is exactly two clock edges per bit.
- R7: With control bit 0 clear, the master samples on the leading clock edge and changes output on the trailing edge. With bit 0 set, it changes output on the leading edge and samples on the trailing edge.
- R8: Control bits 13:12 set the direction. 0 is full-duplex. 1 is receive-only, with mosi held low for the whole word. 2 is transmit-only, where the receive register and its flag are left untouched.
- R9: At the end of a word in full-duplex or receive-only mode, the receive register gets the word zero-extended and the waiting flag sets. Reading the receive register clears the flag.
- R10: Ready and idle both read 0 from the cycle after a word starts until it ends, and 1 otherwise.
- R11: Clearing the enable while a word is shifting abandons the word. The shifter goes idle, the clock returns to its idle level, and no received word is posted.
- R12: The queue enable bit (control bit 25), the word count field (bits 24:18) and the queue start bit are stored with no effect on shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (has a side effect on the receive register) |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| div_exp | input | 4 | Clock divider exponent N |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| spi_cs | output | NCS | Chip-select lines |

## Verification
The assertions assume three things about how the block is driven. div_exp and the direction, phase and length fields change only while the shifter is idle. Only one of bus_wr and bus_rd is set in a cycle. miso changes only away from the system clock edges on which the master samples. The bench changes the control register and div_exp only between words, after polling the idle flag, and it issues single bus accesses on falling clock edges. Its slave model updates miso one cycle after it sees a serial clock edge, and it uses exponents of 2 or more so that this update lands before the next sampling edge.

// File: rtl/spi_mstr_pkg.sv
package spi_mstr_pkg;

  localparam int WORD_W = 32;
  localparam int LEN_W  = 6;

  localparam logic [2:0] IDX_CTL  = 3'd0;
  localparam logic [2:0] IDX_STAT = 3'd1;
  localparam logic [2:0] IDX_QCTL = 3'd2;
  localparam logic [2:0] IDX_TX   = 3'd3;
  localparam logic [2:0] IDX_RX   = 3'd4;

  localparam logic [WORD_W-1:0] CTL_MASK = 32'h07FF_F1FF;

  typedef enum logic [1:0] {
    XM_DUPLEX = 2'd0,
    XM_RXONLY = 2'd1,
    XM_TXONLY = 2'd2,
    XM_SPARE  = 2'd3
  } xmode_e;

  typedef struct packed {
    logic       ena;
    logic       q_en;
    logic [6:0] wcount;
    logic [3:0] sel;
    xmode_e     mode;
    logic [4:0] len_m1;
    logic       tx_en;
    logic       sel_pol;
    logic       ck_pol;
    logic       ck_pha;
  } ctl_t;

  function automatic ctl_t ctl_unpack(input logic [WORD_W-1:0] r);
    ctl_t c;
    c.ck_pha  = r[0];
    c.ck_pol  = r[1];
    c.sel_pol = r[2];
    c.tx_en   = r[3];
    c.len_m1  = r[8:4];
    c.mode    = xmode_e'(r[13:12]);
    c.sel     = r[17:14];
    c.wcount  = r[24:18];
    c.q_en    = r[25];
    c.ena     = r[26];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] ctl_pack(input ctl_t c);
    logic [WORD_W-1:0] r;
    r        = '0;
    r[0]     = c.ck_pha;
    r[1]     = c.ck_pol;
    r[2]     = c.sel_pol;
    r[3]     = c.tx_en;
    r[8:4]   = c.len_m1;
    r[13:12] = c.mode;
    r[17:14] = c.sel;
    r[24:18] = c.wcount;
    r[25]    = c.q_en;
    r[26]    = c.ena;
    return r;
  endfunction

  function automatic logic [LEN_W-1:0] eff_len(input logic [4:0] m1);
    logic [LEN_W-1:0] v;
    v = {1'b0, m1} + 6'd1;
    return (v < 6'd4) ? 6'd4 : v;
  endfunction

  function automatic logic [WORD_W-1:0] len_mask(input logic [LEN_W-1:0] n);
    return {WORD_W{1'b1}} >> (6'd32 - n);
  endfunction

  function automatic logic [15:0] half_ticks(input logic [3:0] e);
    logic [3:0] k;
    k = (e == 4'd0) ? 4'd1 : e;
    return 16'd1 << (k - 4'd1);
  endfunction

  function automatic logic [7:0] stat_pack(input logic rx_av, input logic idle);
    return {1'b0, ~rx_av, 1'b0, 1'b1, 1'b0, idle, idle, rx_av};
  endfunction

endpackage

// File: rtl/spi_mstr_regs.sv
module spi_mstr_regs
  import spi_mstr_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              rx_av,
  input  logic [WORD_W-1:0] rx_word,
  output logic              ena,
  output logic [3:0]        sel,
  output logic              sel_pol,
  output logic              ck_pol,
  output logic              ck_pha,
  output xmode_e            mode,
  output logic [4:0]        len_m1,
  output logic              tx_push,
  output logic [WORD_W-1:0] tx_word,
  output logic              rx_pop
);
  localparam int IW = AW - 3;

  ctl_t ctl_q;
  logic qstart_q;

  logic          aligned;
  logic [IW-1:0] idx;
  logic          hit_ctl, hit_stat, hit_q, hit_tx, hit_rx;

  assign aligned  = (bus_addr[2:0] == 3'b000);
  assign idx      = bus_addr[AW-1:3];
  assign hit_ctl  = aligned && (idx == IW'(IDX_CTL));
  assign hit_stat = aligned && (idx == IW'(IDX_STAT));
  assign hit_q    = aligned && (idx == IW'(IDX_QCTL));
  assign hit_tx   = aligned && (idx == IW'(IDX_TX));
  assign hit_rx   = aligned && (idx == IW'(IDX_RX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= ctl_t'('0);
      qstart_q <= 1'b0;
    end else if (bus_wr) begin
      if (hit_ctl) ctl_q    <= ctl_unpack(bus_wdata);
      if (hit_q)   qstart_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctl)  bus_rdata = ctl_pack(ctl_q);
    if (hit_stat) bus_rdata = {24'd0, stat_pack(rx_av, ~busy)};
    if (hit_q)    bus_rdata = {31'd0, qstart_q};
    if (hit_rx)   bus_rdata = rx_word;
  end

  assign ena     = ctl_q.ena;
  assign sel     = ctl_q.sel;
  assign sel_pol = ctl_q.sel_pol;
  assign ck_pol  = ctl_q.ck_pol;
  assign ck_pha  = ctl_q.ck_pha;
  assign mode    = ctl_q.mode;
  assign len_m1  = ctl_q.len_m1;
  assign tx_push = bus_wr && hit_tx;
  assign tx_word = bus_wdata;
  assign rx_pop  = bus_rd && hit_rx;

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && hit_ctl) |=> $stable(ctl_q)); // R1

endmodule

// File: rtl/spi_mstr_sckgen.sv
module spi_mstr_sckgen #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half,
  output logic          tick
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == half - CW'(1));
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half)); // R4

endmodule

// File: rtl/spi_mstr_shift.sv
module spi_mstr_shift
  import spi_mstr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              tick,
  input  logic [4:0]        len_m1,
  input  logic              ck_pha,
  input  logic              ck_pol,
  input  xmode_e            mode,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              keep_rx,
  output logic [WORD_W-1:0] rx_bits
);
  localparam int EW = LEN_W + 1;

  logic [LEN_W-1:0]  len_q;
  logic [EW-1:0]     edge_q;
  logic              pha_q, pol_q, busy_q, sck_q, done_q;
  xmode_e            mode_q;
  logic [WORD_W-1:0] tx_sh, rx_sh;

  logic [LEN_W-1:0] wlen;
  logic             lead, sample_now, last_edge;

  assign wlen       = eff_len(len_m1);
  assign lead       = ~edge_q[0];
  assign sample_now = lead ^ pha_q;
  assign last_edge  = (edge_q == {len_q, 1'b0} - EW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      edge_q <= '0;
      pha_q  <= 1'b0;
      pol_q  <= 1'b0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      mode_q <= XM_DUPLEX;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        sck_q  <= pol_q;
        edge_q <= '0;
      end else if (start) begin
        busy_q <= 1'b1;
        len_q  <= wlen;
        pha_q  <= ck_pha;
        pol_q  <= ck_pol;
        mode_q <= mode;
        sck_q  <= ck_pol;
        edge_q <= '0;
        rx_sh  <= '0;
        tx_sh  <= (mode == XM_RXONLY) ? '0 : (tx_word << (6'd32 - wlen));
      end else if (busy_q && tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + EW'(1);
        if (sample_now)           rx_sh <= {rx_sh[WORD_W-2:0], miso};
        else if (edge_q != '0)    tx_sh <= tx_sh << 1;
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sck     = busy_q ? sck_q : ck_pol;
  assign mosi    = tx_sh[WORD_W-1];
  assign keep_rx = done_q && (mode_q != XM_TXONLY);
  assign rx_bits = rx_sh & len_mask(len_q);

  AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_q < {len_q, 1'b0})); // R6
  AST_SCK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (sck_q == pol_q)); // R4
  AST_RXONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mode_q == XM_RXONLY) |-> !mosi); // R8

endmodule

// File: rtl/spi_mstr_csdec.sv
module spi_mstr_csdec #(
  parameter int NCS = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ena,
  input  logic [3:0]     sel,
  input  logic           sel_pol,
  output logic [NCS-1:0] lines
);
  logic [NCS-1:0] act;

  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign act[i]   = ena && (sel == 4'(i));
    assign lines[i] = act[i] ? sel_pol : ~sel_pol;
  end

  AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lines ^ {NCS{~sel_pol}})); // R3
  AST_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |-> (lines == {NCS{~sel_pol}})); // R3

endmodule

// File: rtl/spi_mstr_ctl.sv
module spi_mstr_ctl
  import spi_mstr_pkg::*;
#(
  parameter int NCS = 4,
  parameter int AW  = 6,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [3:0]        div_exp,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    spi_cs
);
  logic              ena, sel_pol, ck_pol, ck_pha;
  logic [3:0]        sel;
  xmode_e            mode;
  logic [4:0]        len_m1;
  logic              tx_push, rx_pop, busy, tick, keep_rx;
  logic [WORD_W-1:0] tx_word, rx_bits;
  logic [WORD_W-1:0] rx_q;
  logic              rx_av_q;
  logic              start, abort;
  logic [CW-1:0]     half;

  assign start = tx_push && ena && !busy;
  assign abort = !ena && busy;
  assign half  = CW'(half_ticks(div_exp));

  spi_mstr_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rx_av(rx_av_q), .rx_word(rx_q),
    .ena(ena), .sel(sel), .sel_pol(sel_pol), .ck_pol(ck_pol), .ck_pha(ck_pha),
    .mode(mode), .len_m1(len_m1),
    .tx_push(tx_push), .tx_word(tx_word), .rx_pop(rx_pop)
  );

  spi_mstr_sckgen #(.CW(CW)) u_sckgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .half(half), .tick(tick)
  );

  spi_mstr_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .tick(tick),
    .len_m1(len_m1), .ck_pha(ck_pha), .ck_pol(ck_pol), .mode(mode),
    .tx_word(tx_word), .miso(miso),
    .busy(busy), .sck(sck), .mosi(mosi), .keep_rx(keep_rx), .rx_bits(rx_bits)
  );

  spi_mstr_csdec #(.NCS(NCS)) u_csdec (
    .clk(clk), .rst_n(rst_n), .ena(ena), .sel(sel), .sel_pol(sel_pol), .lines(spi_cs)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_av_q <= 1'b0;
    end else if (keep_rx) begin
      rx_q    <= rx_bits;
      rx_av_q <= 1'b1;
    end else if (rx_pop) begin
      rx_av_q <= 1'b0;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy); // R10
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> !busy); // R11
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && !keep_rx) |=> !rx_av_q); // R9
  AST_DROP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push && busy && ena) |=> busy); // R5

endmodule

// File: tb/spi_mstr_ctl_bench.sv
`timescale 1ns/1ps
module spi_mstr_ctl_bench;
  localparam int NCS = 4;
  localparam int AW  = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  div_exp = 4'd2;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [NCS-1:0] spi_cs;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  bit done_all = 0;

  always #5 clk = ~clk;

  spi_mstr_ctl #(.NCS(NCS), .AW(AW)) u_spi_mstr_ctl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .div_exp(div_exp), .sck(sck), .mosi(mosi), .miso(miso), .spi_cs(spi_cs)
  );

  // slave model
  bit          sl_arm = 0;
  bit          pha_b = 0, pol_b = 0;
  int          sl_edges = 0;
  int          e0 = 0, e1 = 0;
  logic [31:0] sl_tx = '0, sl_rx = '0;
  logic        sck_prev = 1'b0;

  always @(posedge clk) begin
    cyc++;
    if (sl_arm && sck !== sck_prev) begin
      if (sl_edges == 0) e0 = cyc;
      if (sl_edges == 1) e1 = cyc;
      sl_edges++;
      if ((sck != pol_b) ^ pha_b) sl_rx = {sl_rx[30:0], mosi};
      else if (pha_b) begin miso <= sl_tx[31]; sl_tx = sl_tx << 1; end
      else begin sl_tx = sl_tx << 1; miso <= sl_tx[31]; end
    end else if (sl_edges == 0) begin
      miso <= sl_tx[31];
    end
    sck_prev = sck;
  end

  function automatic int blen(input int m1);
    return (m1 + 1 < 4) ? 4 : m1 + 1;
  endfunction

  function automatic logic [31:0] bmask(input int l);
    return (l >= 32) ? 32'hFFFF_FFFF : ((32'd1 << l) - 32'd1);
  endfunction

  function automatic logic [31:0] mkctl(input bit en, input int sel, input bit spol,
                                        input bit pol, input bit pha, input int m1,
                                        input int md, input logic [7:0] junk);
    logic [31:0] r;
    r = '0;
    r[0] = pha; r[1] = pol; r[2] = spol; r[8:4] = 5'(m1);
    r[13:12] = 2'(md); r[17:14] = 4'(sel); r[26] = en;
    r[24:18] = junk[6:0]; r[25] = junk[7];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    rd(6'h08, s);
    while (!s[2] && n < 20000) begin rd(6'h08, s); n++; end
    chk("R10 idle reached", {31'd0, s[2]}, 32'd1);
  endtask

  task automatic xfer(input int m1, input bit pha, input bit pol, input int md,
                      input logic [31:0] txw, input logic [31:0] slw, input int nexp);
    logic [31:0] v, prev;
    int l;
    l = blen(m1);
    div_exp = 4'(nexp);
    wr(6'h00, mkctl(1, $urandom % NCS, $urandom % 2, pol, pha, m1, md, 8'($urandom)));
    wr(6'h10, {31'd0, 1'($urandom)});
    rd(6'h20, prev);
    @(negedge clk);
    pha_b = pha; pol_b = pol;
    sl_tx = slw << (32 - l); sl_rx = '0; sl_edges = 0; sl_arm = 1;
    @(negedge clk);
    wr(6'h18, txw);
    rd(6'h08, v);
    chk("R10 busy flags", {30'd0, v[2:1]}, 32'd0);
    wait_idle();
    sl_arm = 0;
    chk("R6 edge count", sl_edges, 2 * l);
    chk("R7 R8 mosi word", sl_rx & bmask(l), (md == 1) ? 32'd0 : (txw & bmask(l)));
    chk("R4 sck idle", {31'd0, sck}, {31'd0, pol});
    rd(6'h08, v);
    chk("R9 rx flag set", {31'd0, v[0]}, (md == 2) ? 32'd0 : 32'd1);
    rd(6'h20, v);
    chk("R8 R9 rx word", v, (md == 2) ? prev : (slw & bmask(l)));
    rd(6'h08, v);
    chk("R9 rx flag clear", {31'd0, v[0]}, 32'd0);
  endtask

  initial begin
    #1_500_000;
    if (!done_all) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(6'h08, v); chk("R2 reset status", v, 32'h56);
    rd(6'h20, v); chk("R9 reset rx", v, 32'd0);
    rd(6'h00, v); chk("R1 reset ctl", v, 32'd0);
    chk("R3 reset cs", {28'd0, spi_cs}, 32'hF);
    chk("R4 reset sck", {31'd0, sck}, 32'd0);

    // R1 readback masks, misaligned access, queue control
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h00, v); chk("R1 ctl mask", v, 32'h07FF_F1FF);
    wr(6'h01, 32'h0);
    rd(6'h00, v); chk("R1 misaligned write dropped", v, 32'h07FF_F1FF);
    rd(6'h01, v); chk("R1 misaligned read zero", v, 32'd0);
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, v); chk("R12 queue start stored", v, 32'd1);
    rd(6'h18, v); chk("R1 tx reads zero", v, 32'd0);
    wr(6'h00, 32'h0);

    // R3 chip-select decode
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < NCS; k++) begin
        wr(6'h00, mkctl(1, k, p, 0, 0, 7, 0, 8'd0));
        for (int i = 0; i < NCS; i++) begin
          c[i] = (i == k) ? 1'(p) : ~1'(p);
        end
        chk("R3 cs select", {28'd0, spi_cs}, {28'd0, c[3:0]});
      end
      wr(6'h00, mkctl(1, 9, p, 0, 0, 7, 0, 8'd0));
      chk("R3 cs out of range", {28'd0, spi_cs}, p ? 32'h0 : 32'hF);
      wr(6'h00, mkctl(0, 1, p, 0, 0, 7, 0, 8'd0));
      chk("R3 cs disabled", {28'd0, spi_cs}, p ? 32'h0 : 32'hF);
    end

    // R5 write while disabled dropped
    sl_edges = 0; sl_arm = 1; pol_b = 0;
    wr(6'h18, 32'hFF);
    repeat (20) @(negedge clk);
    sl_arm = 0;
    rd(6'h08, v);
    chk("R5 disabled write no word", {29'd0, v[2:0]}, 32'h6);
    chk("R5 disabled write no edges", sl_edges, 0);

    // directed words
    xfer(7, 0, 0, 0, 32'hA5, 32'h3C, 2);                       // R7 phase 0
    xfer(31, 1, 1, 0, 32'hDEAD_BEEF, 32'h1234_5678, 2);        // R6 R7 full width
    xfer(1, 0, 1, 0, 32'h9, 32'h6, 3);                         // R6 clamp to 4
    xfer(15, 1, 0, 1, 32'hFFFF, 32'hBEEF, 2);                  // R8 receive-only
    xfer(11, 0, 0, 2, 32'hABC, 32'h555, 2);                    // R8 transmit-only

    // R4 half period at N=6
    xfer(3, 0, 0, 0, 32'h5, 32'hA, 6);
    chk("R4 half period", e1 - e0, 32);

    // R5 second write while busy dropped
    div_exp = 4'd3;
    wr(6'h00, mkctl(1, 0, 0, 0, 0, 7, 0, 8'd0));
    rd(6'h20, v);
    @(negedge clk);
    pha_b = 0; pol_b = 0; sl_tx = 32'h0; sl_rx = '0; sl_edges = 0; sl_arm = 1;
    @(negedge clk);
    wr(6'h18, 32'h81);
    wr(6'h18, 32'h7E);
    wait_idle();
    sl_arm = 0;
    chk("R5 busy write edges", sl_edges, 16);
    chk("R5 busy write data", sl_rx & 32'hFF, 32'h81);

    // R11 abort mid-word
    div_exp = 4'd4;
    wr(6'h00, mkctl(1, 2, 0, 1, 0, 31, 0, 8'd0));
    rd(6'h20, v);
    wr(6'h18, 32'h1234);
    repeat (40) @(negedge clk);
    wr(6'h00, mkctl(0, 2, 0, 1, 0, 31, 0, 8'd0));
    repeat (3) @(negedge clk);
    rd(6'h08, v);
    chk("R11 abort idle", {29'd0, v[2:0]}, 32'h6);
    chk("R11 abort sck", {31'd0, sck}, 32'd1);

    // random words
    for (int t = 0; t < 40; t++) begin
      int md;
      md = $urandom % 3;
      xfer(3 + ($urandom % 29), 1'($urandom), 1'($urandom), md,
           $urandom, $urandom, 2 + ($urandom % 3));
    end

    done_all = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule